// File: doc/BRIEF.md
# IEEE 1284 Mode Handshake Sequencer

This block is the host-side state machine for the IEEE 1284 mode handshake on a parallel port. A caller asks for a mode by pulsing `neg_req` with an 8-bit extensibility code. The block puts the code on the data lines and steps the four host control lines through the numbered negotiation events. It watches the five peripheral status lines, and it decides from the peripheral's Select answer whether the mode was granted. A second request, `term_req`, runs the termination handshake that returns the link to compatibility mode.

Each wait for the peripheral is bounded by a number of `tick` pulses from an external timebase. The counter reloads on entry to each wait, so a slow or absent peripheral always ends the operation with a timeout instead of hanging. Every operation ends with a one-cycle `hs_done`. At most one outcome flag is raised alongside it. The block only sequences the handshake: it moves no data in the nibble or extended phases.

Top module: `ieee1284_hs_sequencer`

## Requirements
- R1: After reset nStrobe, nAutoFd and nInit are high, nSelectIn is low, `pd_out` is 0x00, `cur_mode` is 2'b00 (compatibility) and all flags are low.
- R2: A `neg_req` (with `term_req` low) arriving while nSelectIn is already high is refused. In the next cycle `hs_done` and `hs_rejected` are high, and the lines, data and mode are unchanged.
- R3: On an accepted `neg_req`, `pd_out` shows the code from the next cycle. The lines stay idle until one setup tick has passed, after which nSelectIn goes high and nAutoFd goes low.
- R4: The block then waits for PError, Select and nFault high with nAck low. The cycle after it sees this, nStrobe goes low. If 6 ticks pass first, the operation ends with `hs_done` and `hs_timeout`.
- R5: nStrobe stays low for one tick. Then nStrobe and nAutoFd both return high.
- R6: The block then waits up to 7 ticks for nAck high. On expiry it ends with `hs_done` and `hs_timeout`.
- R7: When nAck is seen high, the block samples Select in that same cycle. Code 0x00 (nibble) is always accepted and sets `cur_mode` to 2'b01. Any other code is accepted only if Select is high, and sets `cur_mode` to 2'b10. Acceptance raises `hs_accepted`.
- R8: A non-nibble code with Select low raises `hs_rejected`, and `cur_mode` stays 2'b00.
- R9: `term_req` while nSelectIn is low has no effect: the lines do not change and no `hs_done` appears.
- R10: On `term_req` with nSelectIn high, the next cycle shows nSelectIn low with nAutoFd, nStrobe and nInit high. The block then waits up to 7 ticks for Busy and nFault high with nAck low.
- R11: `cur_mode` returns to 2'b00 the cycle after the first termination wait ends, whether it succeeded or timed out.
- R12: After that acknowledge, nAutoFd goes low and the block waits up to 6 ticks for nAck high. nAutoFd returns high in both outcomes, and `hs_timeout` marks the failing one.
- R13: Wait counters advance only on `tick`. No number of cycles without a tick ends a wait.
- R14: `hs_done` is a one-cycle pulse. `hs_accepted`, `hs_rejected` and `hs_timeout` appear only with it, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| neg_req | input | 1 | Start negotiation (sampled in idle) |
| neg_code | input | 8 | Extensibility code to request |
| term_req | input | 1 | Start termination (sampled in idle) |
| st_nack | input | 1 | Peripheral nAck |
| st_busy | input | 1 | Peripheral Busy |
| st_perror | input | 1 | Peripheral PError |
| st_select | input | 1 | Peripheral Select |
| st_nfault | input | 1 | Peripheral nFault |
| tick | input | 1 | Timebase pulse, one cycle wide |
| pd_out | output | 8 | Data lines |
| c_nstrobe | output | 1 | Host nStrobe |
| c_nautofd | output | 1 | Host nAutoFd |
| c_ninit | output | 1 | Host nInit |
| c_nselectin | output | 1 | Host nSelectIn |
| cur_mode | output | 2 | 00 compatibility, 01 nibble, 10 extended |
| hs_done | output | 1 | Operation finished (one cycle) |
| hs_accepted | output | 1 | Requested mode granted |
| hs_rejected | output | 1 | Request refused or mode unsupported |
| hs_timeout | output | 1 | A wait expired |

## Verification
The bench probes the exact tick on which each window closes. A counter that is off by one would time out one tick early or late in the 6-tick and 7-tick waits, and a counter that counts clocks would expire during a long stretch with no tick. It also varies Select against the code: a design that judged acceptance from an earlier Select sample, or did not exempt nibble, would report the wrong outcome. The termination-timeout path is checked too, since a design that only cleared the mode on success would leave the link marked as negotiated. Finally, the bench sends requests at the wrong time, a second negotiation and a termination from idle, to catch a design that restarts the handshake instead of refusing or ignoring it.

// File: rtl/seq1284_pkg.sv
package seq1284_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_N_SETUP,
      S_N_RESP,
      S_N_STROBE,
      S_N_ACK,
      S_T_ACK,
      S_T_FIN
   } hs_state_e;

   typedef enum logic [1:0] {
      MODE_COMPAT = 2'b00,
      MODE_NIBBLE = 2'b01,
      MODE_EXT    = 2'b10
   } hs_mode_e;

   typedef struct packed {
      logic nstrobe;
      logic nautofd;
      logic ninit;
      logic nselectin;
   } host_lines_t;

   localparam host_lines_t LINES_IDLE     = '{nstrobe: 1'b1, nautofd: 1'b1, ninit: 1'b1, nselectin: 1'b0};
   localparam host_lines_t LINES_NEG_REQ  = '{nstrobe: 1'b1, nautofd: 1'b0, ninit: 1'b1, nselectin: 1'b1};
   localparam host_lines_t LINES_TERM_REQ = '{nstrobe: 1'b1, nautofd: 1'b1, ninit: 1'b1, nselectin: 1'b0};

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hs_tick_window.sv
module hs_tick_window #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   output logic          last
);

   logic [CW-1:0] cnt;

   initial begin
      assert (CW >= 1) else $error("hs_tick_window: CW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (tick && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign last = (cnt == CW'(1));

   // R13: without a load or a tick the window never moves
   a_r13_tick_only : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/hs_accept_judge.sv
module hs_accept_judge #(
   parameter logic [7:0] NIBBLE_CODE  = 8'h00,
   parameter bit         FORCE_NIBBLE = 1'b1
) (
   input  logic [7:0] code,
   input  logic       select_now,
   output logic       take,
   output logic       is_nibble
);

   assign is_nibble = (code == NIBBLE_CODE);

   generate
      if (FORCE_NIBBLE) begin : g_nibble_exempt
         assign take = is_nibble | select_now;
      end else begin : g_select_only
         assign take = select_now;
      end
   endgenerate

endmodule

// File: rtl/ieee1284_hs_sequencer.sv
module ieee1284_hs_sequencer
   import seq1284_pkg::*;
#(
   parameter int         SETUP_TICKS    = 1,
   parameter int         RESP_TICKS     = 6,
   parameter int         STROBE_TICKS   = 1,
   parameter int         ACK_TICKS      = 7,
   parameter int         TERM_ACK_TICKS = 7,
   parameter int         TERM_FIN_TICKS = 6,
   parameter logic [7:0] NIBBLE_CODE    = 8'h00,
   parameter bit         FORCE_NIBBLE   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       neg_req,
   input  logic [7:0] neg_code,
   input  logic       term_req,
   input  logic       st_nack,
   input  logic       st_busy,
   input  logic       st_perror,
   input  logic       st_select,
   input  logic       st_nfault,
   input  logic       tick,
   output logic [7:0] pd_out,
   output logic       c_nstrobe,
   output logic       c_nautofd,
   output logic       c_ninit,
   output logic       c_nselectin,
   output logic [1:0] cur_mode,
   output logic       hs_done,
   output logic       hs_accepted,
   output logic       hs_rejected,
   output logic       hs_timeout
);

   localparam int MAX_TICKS = imax(imax(imax(SETUP_TICKS, RESP_TICKS), imax(STROBE_TICKS, ACK_TICKS)),
                                   imax(TERM_ACK_TICKS, TERM_FIN_TICKS));
   localparam int CW = $clog2(MAX_TICKS + 1);
   localparam logic [CW-1:0] L_SETUP  = CW'(SETUP_TICKS);
   localparam logic [CW-1:0] L_RESP   = CW'(RESP_TICKS);
   localparam logic [CW-1:0] L_STROBE = CW'(STROBE_TICKS);
   localparam logic [CW-1:0] L_ACK    = CW'(ACK_TICKS);
   localparam logic [CW-1:0] L_TACK   = CW'(TERM_ACK_TICKS);
   localparam logic [CW-1:0] L_TFIN   = CW'(TERM_FIN_TICKS);

   initial begin
      assert (SETUP_TICKS >= 1 && RESP_TICKS >= 1 && STROBE_TICKS >= 1)
         else $error("ieee1284_hs_sequencer: negotiation windows must be at least one tick");
      assert (ACK_TICKS >= 1 && TERM_ACK_TICKS >= 1 && TERM_FIN_TICKS >= 1)
         else $error("ieee1284_hs_sequencer: acknowledge windows must be at least one tick");
   end

   hs_state_e   s_q, s_d;
   host_lines_t ln_q, ln_d;
   hs_mode_e    mode_q, mode_d;
   logic [7:0]  data_q, data_d;
   logic        done_d, acc_d, rej_d, to_d;
   logic        win_load, win_last, expire;
   logic [CW-1:0] win_val;
   logic        take, is_nibble;
   logic        resp_seen, tack_seen;

   hs_tick_window #(.CW(CW)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (win_load),
      .load_val (win_val),
      .tick     (tick),
      .last     (win_last)
   );

   hs_accept_judge #(.NIBBLE_CODE(NIBBLE_CODE), .FORCE_NIBBLE(FORCE_NIBBLE)) u_judge (
      .code       (data_q),
      .select_now (st_select),
      .take       (take),
      .is_nibble  (is_nibble)
   );

   assign expire    = tick & win_last;
   assign resp_seen = st_perror & st_select & st_nfault & ~st_nack;
   assign tack_seen = st_busy & st_nfault & ~st_nack;

   always_comb begin
      s_d      = s_q;
      ln_d     = ln_q;
      mode_d   = mode_q;
      data_d   = data_q;
      done_d   = 1'b0;
      acc_d    = 1'b0;
      rej_d    = 1'b0;
      to_d     = 1'b0;
      win_load = 1'b0;
      win_val  = '0;
      unique case (s_q)
         S_IDLE: begin
            if (term_req && ln_q.nselectin) begin
               ln_d     = LINES_TERM_REQ;
               s_d      = S_T_ACK;
               win_load = 1'b1;
               win_val  = L_TACK;
            end else if (neg_req) begin
               if (ln_q.nselectin) begin
                  done_d = 1'b1;
                  rej_d  = 1'b1;
               end else begin
                  data_d   = neg_code;
                  s_d      = S_N_SETUP;
                  win_load = 1'b1;
                  win_val  = L_SETUP;
               end
            end
         end
         S_N_SETUP: begin
            if (expire) begin
               ln_d     = LINES_NEG_REQ;
               s_d      = S_N_RESP;
               win_load = 1'b1;
               win_val  = L_RESP;
            end
         end
         S_N_RESP: begin
            if (resp_seen) begin
               ln_d.nstrobe = 1'b0;
               s_d          = S_N_STROBE;
               win_load     = 1'b1;
               win_val      = L_STROBE;
            end else if (expire) begin
               done_d = 1'b1;
               to_d   = 1'b1;
               s_d    = S_IDLE;
            end
         end
         S_N_STROBE: begin
            if (expire) begin
               ln_d.nstrobe = 1'b1;
               ln_d.nautofd = 1'b1;
               s_d          = S_N_ACK;
               win_load     = 1'b1;
               win_val      = L_ACK;
            end
         end
         S_N_ACK: begin
            if (st_nack) begin
               done_d = 1'b1;
               s_d    = S_IDLE;
               if (take) begin
                  acc_d  = 1'b1;
                  mode_d = is_nibble ? MODE_NIBBLE : MODE_EXT;
               end else begin
                  rej_d = 1'b1;
               end
            end else if (expire) begin
               done_d = 1'b1;
               to_d   = 1'b1;
               s_d    = S_IDLE;
            end
         end
         S_T_ACK: begin
            if (tack_seen) begin
               mode_d       = MODE_COMPAT;
               ln_d.nautofd = 1'b0;
               s_d          = S_T_FIN;
               win_load     = 1'b1;
               win_val      = L_TFIN;
            end else if (expire) begin
               mode_d = MODE_COMPAT;
               done_d = 1'b1;
               to_d   = 1'b1;
               s_d    = S_IDLE;
            end
         end
         S_T_FIN: begin
            if (st_nack) begin
               ln_d.nautofd = 1'b1;
               done_d       = 1'b1;
               s_d          = S_IDLE;
            end else if (expire) begin
               ln_d.nautofd = 1'b1;
               done_d       = 1'b1;
               to_d         = 1'b1;
               s_d          = S_IDLE;
            end
         end
         default: s_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q         <= S_IDLE;
         ln_q        <= LINES_IDLE;
         mode_q      <= MODE_COMPAT;
         data_q      <= 8'h00;
         hs_done     <= 1'b0;
         hs_accepted <= 1'b0;
         hs_rejected <= 1'b0;
         hs_timeout  <= 1'b0;
      end else begin
         s_q         <= s_d;
         ln_q        <= ln_d;
         mode_q      <= mode_d;
         data_q      <= data_d;
         hs_done     <= done_d;
         hs_accepted <= acc_d;
         hs_rejected <= rej_d;
         hs_timeout  <= to_d;
      end
   end

   assign pd_out      = data_q;
   assign c_nstrobe   = ln_q.nstrobe;
   assign c_nautofd   = ln_q.nautofd;
   assign c_ninit     = ln_q.ninit;
   assign c_nselectin = ln_q.nselectin;
   assign cur_mode    = mode_q;

   // R14: outcome flags ride on the done pulse, never more than one
   a_r14_flag_with_done : assert property (@(posedge clk) disable iff (!rst_n)
      (hs_accepted || hs_rejected || hs_timeout) |-> hs_done);
   a_r14_single_outcome : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hs_accepted, hs_rejected, hs_timeout}));
   // R5: strobe is only ever low inside the selected, autofd-low phase
   a_r5_strobe_in_phase : assert property (@(posedge clk) disable iff (!rst_n)
      !c_nstrobe |-> (c_nselectin && !c_nautofd));
   // R2: a negotiation request over an active link is refused next cycle
   a_r2_refuse_active : assert property (@(posedge clk) disable iff (!rst_n)
      (s_q == S_IDLE && neg_req && !term_req && c_nselectin) |=> (hs_done && hs_rejected));
   // R9: termination from idle lines changes nothing
   a_r9_term_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (s_q == S_IDLE && term_req && !neg_req && !c_nselectin) |=> (!hs_done && !c_nselectin && c_nautofd));
   // R11: leaving the first termination wait always lands in compatibility
   a_r11_compat_after_tack : assert property (@(posedge clk) disable iff (!rst_n)
      (s_q == S_T_ACK && s_d != S_T_ACK) |=> (cur_mode == MODE_COMPAT));

endmodule

// File: tb/ieee1284_hs_sequencer_test.sv
`timescale 1ns/1ps
module ieee1284_hs_sequencer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       neg_req = 1'b0;
   logic [7:0] neg_code = 8'h00;
   logic       term_req = 1'b0;
   logic       st_nack = 1'b1, st_busy = 1'b0, st_perror = 1'b0, st_select = 1'b0, st_nfault = 1'b1;
   logic       tick = 1'b0;
   logic [7:0] pd_out;
   logic       c_nstrobe, c_nautofd, c_ninit, c_nselectin;
   logic [1:0] cur_mode;
   logic       hs_done, hs_accepted, hs_rejected, hs_timeout;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   ieee1284_hs_sequencer uut (
      .clk(clk), .rst_n(rst_n), .neg_req(neg_req), .neg_code(neg_code), .term_req(term_req),
      .st_nack(st_nack), .st_busy(st_busy), .st_perror(st_perror), .st_select(st_select),
      .st_nfault(st_nfault), .tick(tick), .pd_out(pd_out), .c_nstrobe(c_nstrobe),
      .c_nautofd(c_nautofd), .c_ninit(c_ninit), .c_nselectin(c_nselectin), .cur_mode(cur_mode),
      .hs_done(hs_done), .hs_accepted(hs_accepted), .hs_rejected(hs_rejected), .hs_timeout(hs_timeout)
   );

   // {code[15:8], resp_ok, ack_ok, sel_at_ack, exp_acc, exp_rej, exp_to, exp_mode[1:0]}
   localparam logic [15:0] VEC [6] = '{
      16'h00D1,   // nibble, Select low at ack: still granted
      16'h30F2,   // extended, Select high: granted
      16'h30C8,   // extended, Select low: unsupported
      16'h1004,   // no 1284 response: timeout
      16'h0084,   // response but nAck never returns: timeout
      16'hFFF2    // extended, Select high: granted
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic negotiate(input logic [15:0] v);
      logic [7:0] code = v[15:8];
      st_nack = 1'b1; st_busy = 1'b0; st_perror = 1'b0; st_select = 1'b0; st_nfault = 1'b1;
      neg_code = code; neg_req = 1'b1;
      @(negedge clk);
      neg_req = 1'b0;
      chk("R3 data lines", pd_out, code);
      chk("R3 nSelectIn before setup tick", {7'd0, c_nselectin}, 8'd0);
      pulse_tick();
      chk("R3 nSelectIn after setup", {7'd0, c_nselectin}, 8'd1);
      chk("R3 nAutoFd after setup", {7'd0, c_nautofd}, 8'd0);
      if (!v[7]) begin
         for (int i = 1; i <= 6; i++) begin
            pulse_tick();
            chk("R4 response window", {7'd0, hs_done}, (i == 6) ? 8'd1 : 8'd0);
         end
      end else begin
         st_perror = 1'b1; st_select = 1'b1; st_nack = 1'b0;
         @(negedge clk);
         chk("R4 nStrobe low", {7'd0, c_nstrobe}, 8'd0);
         pulse_tick();
         chk("R5 nStrobe released", {7'd0, c_nstrobe}, 8'd1);
         chk("R5 nAutoFd released", {7'd0, c_nautofd}, 8'd1);
         if (!v[6]) begin
            for (int i = 1; i <= 7; i++) begin
               pulse_tick();
               chk("R6 ack window", {7'd0, hs_done}, (i == 7) ? 8'd1 : 8'd0);
            end
         end else begin
            st_select = v[5]; st_nack = 1'b1;
            @(negedge clk);
            chk("R7 done on nAck high", {7'd0, hs_done}, 8'd1);
         end
      end
      chk("R7 accepted flag", {7'd0, hs_accepted}, {7'd0, v[4]});
      chk("R8 rejected flag", {7'd0, hs_rejected}, {7'd0, v[3]});
      chk("R6 timeout flag", {7'd0, hs_timeout}, {7'd0, v[2]});
      chk("R7 mode", {6'd0, cur_mode}, {6'd0, v[1:0]});
      @(negedge clk);
      chk("R14 done is one cycle", {7'd0, hs_done}, 8'd0);
   endtask

   task automatic terminate(input bit ack_ok, input bit fin_ok);
      st_nack = 1'b1; st_busy = 1'b0; st_nfault = 1'b1;
      term_req = 1'b1;
      @(negedge clk);
      term_req = 1'b0;
      chk("R10 nSelectIn low", {7'd0, c_nselectin}, 8'd0);
      chk("R10 nAutoFd high", {7'd0, c_nautofd}, 8'd1);
      chk("R10 nStrobe/nInit high", {6'd0, c_nstrobe, c_ninit}, 8'd3);
      if (ack_ok) begin
         st_busy = 1'b1; st_nack = 1'b0;
         @(negedge clk);
         chk("R11 mode compat after ack", {6'd0, cur_mode}, 8'd0);
         chk("R12 nAutoFd low", {7'd0, c_nautofd}, 8'd0);
         if (fin_ok) begin
            st_nack = 1'b1;
            @(negedge clk);
            chk("R12 done", {7'd0, hs_done}, 8'd1);
            chk("R12 no timeout", {7'd0, hs_timeout}, 8'd0);
         end else begin
            for (int i = 1; i <= 6; i++) begin
               pulse_tick();
               chk("R12 final window", {7'd0, hs_done}, (i == 6) ? 8'd1 : 8'd0);
            end
            chk("R12 timeout flagged", {7'd0, hs_timeout}, 8'd1);
         end
      end else begin
         for (int i = 1; i <= 7; i++) begin
            pulse_tick();
            chk("R10 ack window", {7'd0, hs_done}, (i == 7) ? 8'd1 : 8'd0);
         end
         chk("R10 timeout flagged", {7'd0, hs_timeout}, 8'd1);
         chk("R11 mode compat after timeout", {6'd0, cur_mode}, 8'd0);
      end
      chk("R12 nAutoFd restored", {7'd0, c_nautofd}, 8'd1);
      st_busy = 1'b0; st_nack = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset lines", {4'd0, c_nstrobe, c_nautofd, c_ninit, c_nselectin}, 8'hE);
      chk("R1 reset mode", {6'd0, cur_mode}, 8'd0);
      chk("R1 reset data", pd_out, 8'h00);
      chk("R1 reset flags", {4'd0, hs_done, hs_accepted, hs_rejected, hs_timeout}, 8'd0);

      // R9: termination over idle lines
      term_req = 1'b1;
      @(negedge clk);
      term_req = 1'b0;
      @(negedge clk);
      chk("R9 lines unchanged", {4'd0, c_nstrobe, c_nautofd, c_ninit, c_nselectin}, 8'hE);
      chk("R9 no done", {7'd0, hs_done}, 8'd0);

      foreach (VEC[k]) begin
         negotiate(VEC[k]);
         if (c_nselectin) terminate(1'b1, 1'b1);
         chk("R11 compat after terminate", {6'd0, cur_mode}, 8'd0);
      end

      // R2: second request over an active link
      negotiate(16'h00D1);
      neg_code = 8'h30; neg_req = 1'b1;
      @(negedge clk);
      neg_req = 1'b0;
      chk("R2 refused done", {7'd0, hs_done}, 8'd1);
      chk("R2 refused flag", {7'd0, hs_rejected}, 8'd1);
      chk("R2 mode kept", {6'd0, cur_mode}, 8'd1);
      chk("R2 data kept", pd_out, 8'h00);
      chk("R2 nSelectIn kept", {7'd0, c_nselectin}, 8'd1);
      @(negedge clk);
      terminate(1'b0, 1'b0);

      // R13: a wait does not end without ticks
      st_nack = 1'b1; neg_code = 8'h10; neg_req = 1'b1;
      @(negedge clk);
      neg_req = 1'b0;
      pulse_tick();
      repeat (30) @(negedge clk);
      chk("R13 no expiry without ticks", {7'd0, hs_done}, 8'd0);
      chk("R13 still selected", {7'd0, c_nselectin}, 8'd1);
      for (int i = 1; i <= 6; i++) begin
         pulse_tick();
         chk("R13 ticks close window", {7'd0, hs_done}, (i == 6) ? 8'd1 : 8'd0);
      end
      chk("R4 timeout flag", {7'd0, hs_timeout}, 8'd1);
      @(negedge clk);
      terminate(1'b1, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule